// File: doc/BRIEF.md
# Program-Bound Physical Key Access Controller

This block stands between software and a raw delay-based physical response circuit so that a raw response to a caller-chosen challenge is never handed out. Each request carries an operation select, the hash of the calling program, and one argument word. Two operations exist. Response mode (bootstrapping) treats the argument as a pre-challenge: it first derives the challenge by mixing the program hash with the pre-challenge, then applies that challenge to the physical circuit and returns its response. Secret mode treats the argument as a challenge: it applies it directly, then mixes the program hash with the response and returns the digest as the secret.

Because the program hash enters the one-way mixing step in both modes, a different program that presents the same challenge receives a different secret, and a caller that wants to obtain a response has to supply a pre-challenge whose derived challenge it cannot choose. The mixing step is a small iterative add-rotate-xor core that runs one round per clock. The physical circuit is reached over a request/acknowledge handshake. The result is a single-cycle pulse, and every intermediate value is wiped from the internal registers once the result has been delivered.

Top module: `cpuf_gate`

## Requirements
- R1: With `req_op` = 0 (response mode), the challenge driven on `puf_chal` equals mix(`req_phash`, `req_arg`), never the raw argument, and `res_data` carries the `puf_resp` value sampled with `puf_ack`.
- R2: With `req_op` = 1 (secret mode), `puf_chal` equals `req_arg` unchanged and `res_data` equals mix(`req_phash`, response); two different program hashes with the same challenge give different secrets.
- R3: mix(x, y) starts with a = x, b = y and runs ROUNDS rounds (default 8, width 32); round r computes s = a + b, a = rotl(s, 7) xor (K xor r), b = rotl(b, 11) xor a, with K the low DW bits of 0x9E3779B97F4A7C15 (0x7F4A7C15 at width 32); the digest is a xor b.
- R4: In response mode `puf_req` is first high in the cycle after the (ROUNDS+1)-th clock edge following the accepting edge, and `res_valid` is high in the cycle right after the edge at which `puf_ack` is sampled high.
- R5: In secret mode `puf_req` is high in the cycle right after the accepting edge, and `res_valid` is high in the cycle after the (ROUNDS+1)-th edge following the edge that samples `puf_ack` high.
- R6: `req_ready` is high only when idle; it drops after an accepting edge and returns in the cycle after the `res_valid` pulse; a request presented while busy is not taken and does not alter the running result.
- R7: `res_valid` is a single-cycle pulse and `res_data` is zero in every cycle where `res_valid` is low.
- R8: `puf_req` stays high with `puf_chal` stable until `puf_ack` is sampled high, drops at that edge, and `puf_chal` is zero whenever `puf_req` is low.
- R9: During and right after reset `req_ready` is 1 and `puf_req`, `puf_chal`, `res_valid` and `res_data` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 1 | 0 = response mode, 1 = secret mode |
| req_phash | input | DW | Hash of the calling program |
| req_arg | input | DW | Pre-challenge (mode 0) or challenge (mode 1) |
| puf_req | output | 1 | Challenge valid towards the physical circuit |
| puf_chal | output | DW | Challenge applied to the physical circuit |
| puf_ack | input | 1 | Response valid from the physical circuit |
| puf_resp | input | DW | Response word |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DW | Response (mode 0) or secret (mode 1) |

## Verification
The bound checker watches on every cycle the result strobe shape and zero data outside it, the handshake holding and dropping rule with a zero idle challenge, the busy hold-off of `req_ready`, the direct pass-through of the challenge in secret mode and the response capture in response mode. What a property cannot express compactly, the value of the mixing digest and the exact round-dependent latencies, is shown by the bench's cycle reference model, which recomputes the mixing function on its own and compares every output each clock under varying acknowledge delays, several program hashes, back-to-back requests and a request held during a busy period.

// File: rtl/cpuf_pkg.sv
package cpuf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE_HASH,
      ST_PUF,
      ST_POST_HASH,
      ST_OUT
   } ctl_state_e;

   typedef enum logic {
      OP_GET_RESPONSE = 1'b0,
      OP_GET_SECRET   = 1'b1
   } cpuf_op_e;

   // Round key seed; the low DW bits are used.
   localparam logic [63:0] MIX_KEY_SEED = 64'h9E37_79B9_7F4A_7C15;

endpackage

// File: rtl/cpuf_mix.sv
module cpuf_mix
   import cpuf_pkg::*;
#(
   parameter int DW     = 32,
   parameter int ROUNDS = 8,
   parameter int ROT_A  = 7,
   parameter int ROT_B  = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] x_in,
   input  logic [DW-1:0] y_in,
   output logic          done,
   output logic [DW-1:0] digest
);

   localparam int CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ROUNDS - 1);
   localparam logic [DW-1:0] KEY = MIX_KEY_SEED[DW-1:0];

   initial begin
      if (ROT_A < 1 || ROT_A >= DW) $error("cpuf_mix: ROT_A out of range");
      if (ROT_B < 1 || ROT_B >= DW) $error("cpuf_mix: ROT_B out of range");
      if (ROUNDS < 1) $error("cpuf_mix: ROUNDS must be at least 1");
   end

   logic [DW-1:0]    a_q, b_q;
   logic             busy_q, done_q;
   logic             last_round;
   logic [CNT_W-1:0] rnd_idx;
   logic [DW-1:0]    sum, a_nx, b_nx;

   generate
      if (ROUNDS == 1) begin : g_single
         assign last_round = 1'b1;
         assign rnd_idx    = '0;
      end else begin : g_multi
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (start)  cnt_q <= '0;
            else if (busy_q) cnt_q <= cnt_q + 1'b1;
         end
         assign last_round = (cnt_q == LAST_IDX);
         assign rnd_idx    = cnt_q;
      end
   endgenerate

   // One add-rotate-xor round per clock.
   assign sum  = a_q + b_q;
   assign a_nx = {sum[DW-1-ROT_A:0], sum[DW-1:DW-ROT_A]} ^ (KEY ^ DW'(rnd_idx));
   assign b_nx = {b_q[DW-1-ROT_B:0], b_q[DW-1:DW-ROT_B]} ^ a_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q    <= '0;
         b_q    <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else if (start) begin
         a_q    <= x_in;
         b_q    <= y_in;
         busy_q <= 1'b1;
         done_q <= 1'b0;
      end else if (busy_q) begin
         a_q <= a_nx;
         b_q <= b_nx;
         if (last_round) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end
      end else if (done_q) begin
         // digest consumed this cycle; wipe the state
         a_q    <= '0;
         b_q    <= '0;
         done_q <= 1'b0;
      end
   end

   assign done   = done_q;
   assign digest = a_q ^ b_q;

endmodule

// File: rtl/cpuf_puf_link.sv
module cpuf_puf_link #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] chal_in,
   output logic          puf_req,
   output logic [DW-1:0] puf_chal,
   input  logic          puf_ack,
   output logic          done
);

   logic          req_q;
   logic [DW-1:0] chal_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         chal_q <= '0;
      end else if (start) begin
         req_q  <= 1'b1;
         chal_q <= chal_in;
      end else if (req_q && puf_ack) begin
         req_q  <= 1'b0;
         chal_q <= '0;
      end
   end

   assign puf_req  = req_q;
   assign puf_chal = chal_q;
   assign done     = req_q & puf_ack;

endmodule

// File: rtl/cpuf_gate.sv
module cpuf_gate
   import cpuf_pkg::*;
#(
   parameter int DW     = 32,
   parameter int ROUNDS = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_op,
   input  logic [DW-1:0] req_phash,
   input  logic [DW-1:0] req_arg,
   output logic          puf_req,
   output logic [DW-1:0] puf_chal,
   input  logic          puf_ack,
   input  logic [DW-1:0] puf_resp,
   output logic          res_valid,
   output logic [DW-1:0] res_data
);

   initial begin
      if (DW < 16 || DW > 64) $error("cpuf_gate: DW must lie in 16..64");
      if (ROUNDS < 1) $error("cpuf_gate: ROUNDS must be at least 1");
   end

   ctl_state_e    state_q;
   cpuf_op_e      op_q;
   logic [DW-1:0] phash_q;
   logic          res_valid_q;
   logic [DW-1:0] res_data_q;

   logic          fire, idle;
   logic          mix_start, mix_done;
   logic [DW-1:0] mix_x, mix_y, mix_digest;
   logic          link_start, link_done;
   logic [DW-1:0] link_chal;

   assign idle = (state_q == ST_IDLE);
   assign fire = req_valid & idle;

   assign mix_start = (fire && req_op == OP_GET_RESPONSE) ||
                      (state_q == ST_PUF && link_done && op_q == OP_GET_SECRET);
   assign mix_x     = idle ? req_phash : phash_q;
   assign mix_y     = idle ? req_arg   : puf_resp;

   assign link_start = (fire && req_op == OP_GET_SECRET) ||
                       (state_q == ST_PRE_HASH && mix_done);
   assign link_chal  = idle ? req_arg : mix_digest;

   cpuf_mix #(.DW(DW), .ROUNDS(ROUNDS)) u_mix (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (mix_start),
      .x_in   (mix_x),
      .y_in   (mix_y),
      .done   (mix_done),
      .digest (mix_digest)
   );

   cpuf_puf_link #(.DW(DW)) u_link (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (link_start),
      .chal_in  (link_chal),
      .puf_req  (puf_req),
      .puf_chal (puf_chal),
      .puf_ack  (puf_ack),
      .done     (link_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         op_q        <= OP_GET_RESPONSE;
         phash_q     <= '0;
         res_valid_q <= 1'b0;
         res_data_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (fire) begin
                  op_q    <= cpuf_op_e'(req_op);
                  phash_q <= req_phash;
                  state_q <= (req_op == OP_GET_SECRET) ? ST_PUF : ST_PRE_HASH;
               end
            end
            ST_PRE_HASH: begin
               if (mix_done) state_q <= ST_PUF;
            end
            ST_PUF: begin
               if (link_done) begin
                  if (op_q == OP_GET_RESPONSE) begin
                     res_valid_q <= 1'b1;
                     res_data_q  <= puf_resp;
                     state_q     <= ST_OUT;
                  end else begin
                     state_q <= ST_POST_HASH;
                  end
               end
            end
            ST_POST_HASH: begin
               if (mix_done) begin
                  res_valid_q <= 1'b1;
                  res_data_q  <= mix_digest;
                  state_q     <= ST_OUT;
               end
            end
            ST_OUT: begin
               // result delivered: clear everything that held key material
               res_valid_q <= 1'b0;
               res_data_q  <= '0;
               phash_q     <= '0;
               op_q        <= OP_GET_RESPONSE;
               state_q     <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = idle;
   assign res_valid = res_valid_q;
   assign res_data  = res_data_q;

endmodule

// File: rtl/cpuf_gate_chk.sv
module cpuf_gate_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          req_op,
   input logic [DW-1:0] req_arg,
   input logic          puf_req,
   input logic [DW-1:0] puf_chal,
   input logic          puf_ack,
   input logic [DW-1:0] puf_resp,
   input logic          res_valid,
   input logic [DW-1:0] res_data,
   input logic          op_q
);

   assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   assert_data_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> res_data == '0);

   assert_chal_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !puf_req |-> puf_chal == '0);

   assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (puf_req && !puf_ack) |=> (puf_req && $stable(puf_chal)));

   assert_req_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (puf_req && puf_ack) |=> !puf_req);

   assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_ready_after_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> req_ready);

   assert_not_ready_in_handshake_R6: assert property (@(posedge clk) disable iff (!rst_n)
      puf_req |-> !req_ready);

   // R2 and R5: secret mode drives the caller's challenge at once
   assert_direct_chal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_op) |=> (puf_req && puf_chal == $past(req_arg)));

   assert_resp_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (puf_req && puf_ack && !op_q) |=> (res_valid && res_data == $past(puf_resp)));

endmodule

bind cpuf_gate cpuf_gate_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_op    (req_op),
   .req_arg   (req_arg),
   .puf_req   (puf_req),
   .puf_chal  (puf_chal),
   .puf_ack   (puf_ack),
   .puf_resp  (puf_resp),
   .res_valid (res_valid),
   .res_data  (res_data),
   .op_q      (op_q)
);

// File: tb/cpuf_gate_tb.sv
module cpuf_gate_tb;

   localparam int DW     = 32;
   localparam int ROUNDS = 8;
   localparam logic [DW-1:0] KEY = 32'h7F4A_7C15;

   localparam int P_IDLE = 0, P_PRE = 1, P_PUF = 2, P_POST = 3, P_OUT = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_op = 1'b0;
   logic [DW-1:0] req_phash = '0;
   logic [DW-1:0] req_arg = '0;
   logic          puf_ack = 1'b0;
   logic [DW-1:0] puf_resp = '0;
   logic          req_ready, puf_req, res_valid;
   logic [DW-1:0] puf_chal, res_data;

   int errors = 0;
   int checks = 0;
   int lat = 0;
   int wait_cnt = 0;
   int cyc = 0;
   bit chk_en = 1'b0;
   bit finished = 1'b0;
   logic [DW-1:0] last_chal = '0;

   always #10 clk = ~clk;

   cpuf_gate #(.DW(DW), .ROUNDS(ROUNDS)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_phash(req_phash), .req_arg(req_arg),
      .puf_req(puf_req), .puf_chal(puf_chal), .puf_ack(puf_ack), .puf_resp(puf_resp),
      .res_valid(res_valid), .res_data(res_data)
   );

   function automatic logic [DW-1:0] mix(input logic [DW-1:0] x, input logic [DW-1:0] y);
      logic [DW-1:0] a, b, s;
      a = x;
      b = y;
      for (int r = 0; r < ROUNDS; r++) begin
         s = a + b;
         a = ((s << 7) | (s >> (DW - 7))) ^ (KEY ^ DW'(r));
         b = ((b << 11) | (b >> (DW - 11))) ^ a;
      end
      return a ^ b;
   endfunction

   function automatic logic [DW-1:0] puf_fn(input logic [DW-1:0] c);
      return (c * 32'h2545_F491) ^ {c[15:0], c[31:16]} ^ 32'h5A5A_C3C3;
   endfunction

   task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Physical circuit model: acknowledges after lat idle cycles.
   always @(negedge clk) begin
      if (rst_n && puf_req && !puf_ack) begin
         if (wait_cnt >= lat) begin
            puf_ack   = 1'b1;
            puf_resp  = puf_fn(puf_chal);
            last_chal = puf_chal;
            wait_cnt  = 0;
         end else begin
            wait_cnt++;
         end
      end else begin
         puf_ack = 1'b0;
      end
   end

   // Cycle reference model.
   int            m_ph = P_IDLE;
   int            m_cnt = 0;
   logic          m_op = 1'b0;
   logic [DW-1:0] m_hash = '0, m_chal = '0, m_res = '0;

   always @(posedge clk) begin
      if (!rst_n) m_ph = P_IDLE;
      else begin
         case (m_ph)
            P_IDLE: if (req_valid) begin
               m_op   = req_op;
               m_hash = req_phash;
               if (req_op) begin m_chal = req_arg; m_ph = P_PUF; end
               else begin m_chal = mix(req_phash, req_arg); m_cnt = 0; m_ph = P_PRE; end
            end
            P_PRE: begin m_cnt++; if (m_cnt == ROUNDS + 1) m_ph = P_PUF; end
            P_PUF: if (puf_ack) begin
               if (!m_op) begin m_res = puf_resp; m_ph = P_OUT; end
               else begin m_res = mix(m_hash, puf_resp); m_cnt = 0; m_ph = P_POST; end
            end
            P_POST: begin m_cnt++; if (m_cnt == ROUNDS + 1) m_ph = P_OUT; end
            default: m_ph = P_IDLE;
         endcase
      end
   end

   always @(negedge clk) begin
      if (chk_en && !finished) begin
         chk(DW'(req_ready), DW'(m_ph == P_IDLE), "R6 req_ready");
         chk(DW'(puf_req), DW'(m_ph == P_PUF), m_op ? "R5 puf_req timing" : "R4 puf_req timing");
         chk(puf_chal, (m_ph == P_PUF) ? m_chal : '0, m_op ? "R2 puf_chal" : "R1 puf_chal");
         chk(DW'(res_valid), DW'(m_ph == P_OUT), m_op ? "R5 res_valid timing" : "R4 res_valid timing");
         if (m_ph == P_OUT) chk(res_data, m_res, m_op ? "R2 res_data" : "R1 res_data");
         else               chk(res_data, '0, "R7 res_data idle");
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected<=100000 cycles", cyc);
         summary();
      end
   end

   task automatic run_req(input logic op, input logic [DW-1:0] ph, input logic [DW-1:0] arg,
                          input int l, output logic [DW-1:0] got);
      int t;
      lat = l;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_phash = ph; req_arg = arg;
      t = 0;
      while (!req_ready && t < 1000) begin @(negedge clk); t++; end
      @(negedge clk);
      req_valid = 1'b0;
      t = 0;
      while (!res_valid && t < 1000) begin @(negedge clk); t++; end
      got = res_data;
      if (t >= 1000) begin
         checks++; errors++;
         $display("FAIL R7 no result strobe actual=0 expected=1");
      end
   endtask

   initial begin
      logic [DW-1:0] got, s1, s2, ra;
      int t;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(DW'(req_ready), 1, "R9 ready in reset");
      chk(DW'(puf_req), 0, "R9 puf_req in reset");
      chk(puf_chal, 0, "R9 puf_chal in reset");
      chk(DW'(res_valid), 0, "R9 res_valid in reset");
      chk(res_data, 0, "R9 res_data in reset");
      chk_en = 1'b1;
      rst_n = 1'b1;
      @(negedge clk);
      chk(DW'(req_ready), 1, "R9 ready after reset");

      // R1, R3: response mode, immediate and delayed acknowledge
      run_req(1'b0, 32'h1234_5678, 32'hCAFE_0001, 0, got);
      chk(got, puf_fn(mix(32'h1234_5678, 32'hCAFE_0001)), "R1 R3 response value");
      chk(last_chal, mix(32'h1234_5678, 32'hCAFE_0001), "R1 derived challenge");
      chk(DW'(last_chal != 32'hCAFE_0001), 1, "R1 raw argument not applied");
      run_req(1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 3, got);
      chk(got, puf_fn(mix(32'hFFFF_FFFF, 32'h0)), "R1 response value lat3");

      // R2, R3: secret mode, binding to program hash
      run_req(1'b1, 32'hAAAA_0001, 32'h0BAD_F00D, 2, s1);
      chk(s1, mix(32'hAAAA_0001, puf_fn(32'h0BAD_F00D)), "R2 R3 secret value");
      chk(last_chal, 32'h0BAD_F00D, "R2 challenge applied unchanged");
      run_req(1'b1, 32'hAAAA_0002, 32'h0BAD_F00D, 0, s2);
      chk(s2, mix(32'hAAAA_0002, puf_fn(32'h0BAD_F00D)), "R2 secret other hash");
      chk(DW'(s1 != s2), 1, "R2 different program different secret");

      // R5: secret from a bootstrapped challenge, longer acknowledge delay
      ra = mix(32'h5555_AAAA, 32'h0000_0042);
      run_req(1'b1, 32'h5555_AAAA, ra, 5, got);
      chk(got, mix(32'h5555_AAAA, puf_fn(ra)), "R5 secret from derived challenge");

      // R6: request held while busy must not disturb the running one
      lat = 1;
      @(negedge clk);
      req_valid = 1'b1; req_op = 1'b1; req_phash = 32'h0101_0101; req_arg = 32'h7777_0000;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_op = 1'b0; req_phash = 32'h9999_9999; req_arg = 32'h3333_3333;
      t = 0;
      while (!res_valid && t < 1000) begin @(negedge clk); t++; end
      chk(res_data, mix(32'h0101_0101, puf_fn(32'h7777_0000)), "R6 busy request ignored");
      @(negedge clk);
      chk(DW'(req_ready), 1, "R6 ready after result");
      @(negedge clk);
      req_valid = 1'b0;
      t = 0;
      while (!res_valid && t < 1000) begin @(negedge clk); t++; end
      chk(res_data, puf_fn(mix(32'h9999_9999, 32'h3333_3333)), "R6 held request taken later");

      // R7, R8: back-to-back mixed traffic
      run_req(1'b0, 32'h0000_0001, 32'h0000_0002, 4, got);
      chk(got, puf_fn(mix(32'h1, 32'h2)), "R8 response after long handshake");
      run_req(1'b1, 32'h0000_0001, 32'h0000_0002, 0, got);
      chk(got, mix(32'h1, puf_fn(32'h2)), "R7 secret back-to-back");
      repeat (4) @(negedge clk);
      chk(res_data, 0, "R7 data cleared after result");
      chk(puf_chal, 0, "R8 challenge cleared after handshake");
      summary();
   end

endmodule